// File: doc/BRIEF.md
# Bus Handshake Controller

This clocked controller sits between a bus master and a local device. It carries out four-phase handshakes on both sides. The master requests a transfer by raising either a read strobe or a write strobe. The controller then drives three outputs in a fixed order: a strobe to the device, an enable for the data transceiver and an acknowledge back to the master. Each step waits for the input edge it depends on.

The read and write cycles place the transceiver enable differently around the device handshake:

- In a read, the enable comes on once the device has acknowledged.
- In a write, the enable comes on before the device strobe is raised, and it goes off once the device acknowledges.

On release, the device strobe and the master acknowledge fall together. The controller then waits until the device acknowledge has dropped before it can leave for a new cycle.

All three inputs are asynchronous. Each passes through a two-flop synchroniser, and the controller advances by at most one state per clock. If both strobes are present while the controller is idle, a read cycle is run and a sticky error flag is raised.

Top module: `bhc_top`

## Requirements

In what follows, the output vector is written as {dev_strobe_o, xcvr_en_o, bus_ack_o}, most significant bit first.

- R1: While rst is high at a clock edge, all three outputs and proto_err_o are 0 after that edge.
- R2: Each input passes through two flops. A strobe that goes high before rising edge k, with the controller idle and the device acknowledge low, gives its first output change just after edge k+2 and not before.
- R3: A read cycle drives the output vector through 100, then 110 only after dev_ack_i is high, then 111.
- R4: In a read cycle, after rd_strobe_i falls the vector goes to 101 and then straight to 000. The device strobe and the bus acknowledge fall in the same cycle.
- R5: A write cycle drives the vector through 010, then 110, then 100 only after dev_ack_i is high, then 101.
- R6: In a write cycle, after wr_strobe_i falls the vector goes from 101 straight to 000.
- R7: The device strobe never rises while the synchronised dev_ack_i is high. After a cycle ends, a new cycle is held off until dev_ack_i has gone low.
- R8: Both strobes high while idle start a read cycle and set proto_err_o. proto_err_o then stays 1 until reset.
- R9: Strobe changes outside the idle state neither change the cycle in progress nor set proto_err_o.
- R10: The bus acknowledge rises only while the device strobe is high, and the device strobe was already high in the previous cycle.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_strobe_i | input | 1 | Master read request, asynchronous |
| wr_strobe_i | input | 1 | Master write request, asynchronous |
| dev_ack_i | input | 1 | Device acknowledge, asynchronous |
| dev_strobe_o | output | 1 | Strobe to the local device |
| xcvr_en_o | output | 1 | Data transceiver enable |
| bus_ack_o | output | 1 | Acknowledge to the master |
| proto_err_o | output | 1 | Sticky flag: both strobes seen while idle |

## Verification

The in-line properties check, on every cycle, the orderings that must hold under any input timing:

- the device strobe rises only while the acknowledge is low (R7);
- the transceiver enable comes before or under the device strobe, depending on the cycle type (R3, R5);
- the bus acknowledge rises only under the device strobe (R10);
- the error flag is sticky (R8).

The complete output sequences of each cycle type need the bench's scenarios, because they depend on a cooperating master and device. These scenarios cover the simultaneous release falls, the exact synchroniser latency, the stall while the device still acknowledges, and the rejection of strobe activity away from idle.

// File: rtl/bhc_pkg.sv
package bhc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_RD_REQ  = 4'd1,
    ST_RD_DEN  = 4'd2,
    ST_RD_ACK  = 4'd3,
    ST_RD_DOFF = 4'd4,
    ST_WR_DEN  = 4'd5,
    ST_WR_REQ  = 4'd6,
    ST_WR_DOFF = 4'd7,
    ST_WR_ACK  = 4'd8,
    ST_DRAIN   = 4'd9
  } hs_state_e;

  typedef struct packed {
    logic strobe;
    logic xcvr;
    logic ack;
  } hs_drive_t;

  // Output levels held in each state
  function automatic hs_drive_t drive_of(hs_state_e s);
    hs_drive_t d;
    d = '0;
    unique case (s)
      ST_RD_REQ:  d = '{strobe: 1'b1, xcvr: 1'b0, ack: 1'b0};
      ST_RD_DEN:  d = '{strobe: 1'b1, xcvr: 1'b1, ack: 1'b0};
      ST_RD_ACK:  d = '{strobe: 1'b1, xcvr: 1'b1, ack: 1'b1};
      ST_RD_DOFF: d = '{strobe: 1'b1, xcvr: 1'b0, ack: 1'b1};
      ST_WR_DEN:  d = '{strobe: 1'b0, xcvr: 1'b1, ack: 1'b0};
      ST_WR_REQ:  d = '{strobe: 1'b1, xcvr: 1'b1, ack: 1'b0};
      ST_WR_DOFF: d = '{strobe: 1'b1, xcvr: 1'b0, ack: 1'b0};
      ST_WR_ACK:  d = '{strobe: 1'b1, xcvr: 1'b0, ack: 1'b1};
      default:    d = '0;
    endcase
    return d;
  endfunction

  function automatic logic is_read_state(hs_state_e s);
    return (s == ST_RD_REQ) || (s == ST_RD_DEN) || (s == ST_RD_ACK) || (s == ST_RD_DOFF);
  endfunction

  function automatic logic is_write_state(hs_state_e s);
    return (s == ST_WR_DEN) || (s == ST_WR_REQ) || (s == ST_WR_DOFF) || (s == ST_WR_ACK);
  endfunction

endpackage

// File: rtl/bhc_sync.sv
module bhc_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign sync_o = stage_q[LAST];

  initial begin
    if (STAGES < 2) $error("bhc_sync needs at least two stages");
  end
endmodule

// File: rtl/bhc_fsm.sv
module bhc_fsm
  import bhc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      rd_s,
  input  logic      wr_s,
  input  logic      ack_s,
  output hs_state_e state_o,
  output logic      err_o
);
  hs_state_e state_q, state_d;
  logic      err_q;
  logic      idle_clash;

  assign idle_clash = (state_q == ST_IDLE) && rd_s && wr_s;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (!ack_s) begin
          if (rd_s)      state_d = ST_RD_REQ;
          else if (wr_s) state_d = ST_WR_DEN;
        end
      end
      ST_RD_REQ:  if (ack_s)  state_d = ST_RD_DEN;
      ST_RD_DEN:              state_d = ST_RD_ACK;
      ST_RD_ACK:  if (!rd_s)  state_d = ST_RD_DOFF;
      ST_RD_DOFF:             state_d = ST_DRAIN;
      ST_WR_DEN:  if (!ack_s) state_d = ST_WR_REQ;
      ST_WR_REQ:  if (ack_s)  state_d = ST_WR_DOFF;
      ST_WR_DOFF:             state_d = ST_WR_ACK;
      ST_WR_ACK:  if (!wr_s)  state_d = ST_DRAIN;
      ST_DRAIN:   if (!ack_s) state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_q | idle_clash;
    end
  end

  assign state_o = state_q;
  assign err_o   = err_q;

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $past(err_q) |-> err_q);

  // R9
  err_only_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> $past(state_q == ST_IDLE));
endmodule

// File: rtl/bhc_top.sv
module bhc_top
  import bhc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_strobe_i,
  input  logic wr_strobe_i,
  input  logic dev_ack_i,
  output logic dev_strobe_o,
  output logic xcvr_en_o,
  output logic bus_ack_o,
  output logic proto_err_o
);
  localparam int N_IN = 3;

  logic [N_IN-1:0] raw_in, sync_in;
  logic            rd_s, wr_s, ack_s;
  hs_state_e       state;
  hs_drive_t       drv;
  logic            in_read, in_write;

  assign raw_in = {rd_strobe_i, wr_strobe_i, dev_ack_i};

  bhc_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (raw_in),
    .sync_o  (sync_in)
  );

  assign {rd_s, wr_s, ack_s} = sync_in;

  bhc_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .rd_s    (rd_s),
    .wr_s    (wr_s),
    .ack_s   (ack_s),
    .state_o (state),
    .err_o   (proto_err_o)
  );

  assign drv          = drive_of(state);
  assign dev_strobe_o = drv.strobe;
  assign xcvr_en_o    = drv.xcvr;
  assign bus_ack_o    = drv.ack;
  assign in_read      = is_read_state(state);
  assign in_write     = is_write_state(state);

  // R7
  strobe_rise_ack_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dev_strobe_o) |-> !$past(ack_s));

  // R3
  rd_xcvr_under_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(xcvr_en_o) && in_read) |-> (dev_strobe_o && $past(dev_strobe_o)));

  // R5
  wr_xcvr_first_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(dev_strobe_o) && in_write) |-> $past(xcvr_en_o));

  // R10
  ack_under_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_ack_o) |-> (dev_strobe_o && $past(dev_strobe_o)));
endmodule

// File: tb/bhc_top_bench.sv
module bhc_top_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd = 1'b0, wr = 1'b0, dack = 1'b0;
  logic lds, den, dtk, err;
  logic [2:0] obs;

  always #10 clk = ~clk;  // 50 MHz

  bhc_top u_bhc_top (
    .clk(clk), .rst(rst), .rd_strobe_i(rd), .wr_strobe_i(wr), .dev_ack_i(dack),
    .dev_strobe_o(lds), .xcvr_en_o(den), .bus_ack_o(dtk), .proto_err_o(err)
  );

  assign obs = {lds, den, dtk};

  typedef struct { logic [2:0] v; string tag; } exp_t;
  exp_t exp_q [$];
  int total = 0, fails = 0;
  bit done = 1'b0;
  logic [2:0] prev = 3'b000;

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push_exp(logic [2:0] v, string tag);
    exp_t e;
    e.v = v; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic push_read(string t1, string t2);
    push_exp(3'b100, t1); push_exp(3'b110, t1); push_exp(3'b111, t1);
    push_exp(3'b101, t2); push_exp(3'b000, t2);
  endtask

  task automatic push_write(string t1, string t2);
    push_exp(3'b010, t1); push_exp(3'b110, t1); push_exp(3'b100, t1);
    push_exp(3'b101, t1); push_exp(3'b000, t2);
  endtask

  task automatic wait_bit(int idx, logic val, string tag);
    int n = 0;
    while (obs[idx] !== val && n < 500) begin
      @(negedge clk);
      n++;
    end
    if (n >= 500) check(1'b0, {tag, " timeout"}, obs[idx], val);
  endtask

  // Monitor: each change of the output vector is compared with the queue
  always @(negedge clk) begin
    if (rst) prev <= 3'b000;
    else if (obs !== prev) begin
      if (exp_q.size() == 0) check(1'b0, "unexpected change", obs, prev);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        check(obs === e.v, e.tag, obs, e.v);
      end
      prev <= obs;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(obs === 3'b000, "R1 outputs in reset", obs, 0);
    check(err === 1'b0, "R1 error in reset", err, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R2 latency, R3/R4 read cycle
    push_read("R3", "R4");
    rd = 1'b1;
    @(negedge clk); @(negedge clk);
    check(lds === 1'b0, "R2 no change before edge k+2", lds, 0);
    @(negedge clk);
    check(lds === 1'b1, "R2 change just after edge k+2", lds, 1);
    repeat (3) @(negedge clk);
    check(den === 1'b0, "R3 enable waits for device ack", den, 0);
    dack = 1'b1;
    wait_bit(0, 1'b1, "R3");
    repeat (2) @(negedge clk);
    rd = 1'b0;
    wait_bit(2, 1'b0, "R4");
    repeat (2) @(negedge clk);
    dack = 1'b0;
    repeat (6) @(negedge clk);

    // R5/R6 write cycle
    push_write("R5", "R6");
    wr = 1'b1;
    wait_bit(2, 1'b1, "R5");
    repeat (3) @(negedge clk);
    check(obs === 3'b110, "R5 holds until device ack", obs, 6);
    dack = 1'b1;
    wait_bit(0, 1'b1, "R5");
    repeat (2) @(negedge clk);
    wr = 1'b0;
    wait_bit(2, 1'b0, "R6");
    repeat (2) @(negedge clk);
    dack = 1'b0;
    repeat (6) @(negedge clk);

    // R9: write strobe during a read is ignored
    push_read("R9", "R9");
    rd = 1'b1;
    wait_bit(2, 1'b1, "R9");
    wr = 1'b1;
    repeat (4) @(negedge clk);
    dack = 1'b1;
    wait_bit(0, 1'b1, "R9");
    wr = 1'b0;
    repeat (6) @(negedge clk);
    rd = 1'b0;
    wait_bit(2, 1'b0, "R9");
    dack = 1'b0;
    repeat (6) @(negedge clk);
    check(err === 1'b0, "R9 no error outside idle", err, 0);

    // R7: next cycle held while device ack stays high
    push_write("R7", "R7");
    push_read("R7", "R7");
    wr = 1'b1;
    wait_bit(2, 1'b1, "R7");
    repeat (2) @(negedge clk);
    dack = 1'b1;
    wait_bit(0, 1'b1, "R7");
    wr = 1'b0;
    wait_bit(2, 1'b0, "R7");
    rd = 1'b1;
    repeat (20) @(negedge clk);
    check(obs === 3'b000, "R7 held while device ack high", obs, 0);
    dack = 1'b0;
    wait_bit(2, 1'b1, "R7");
    repeat (2) @(negedge clk);
    dack = 1'b1;
    wait_bit(0, 1'b1, "R7");
    rd = 1'b0;
    wait_bit(2, 1'b0, "R7");
    dack = 1'b0;
    repeat (6) @(negedge clk);

    // R8: both strobes while idle
    check(err === 1'b0, "R8 error clear before clash", err, 0);
    push_read("R8", "R8");
    rd = 1'b1; wr = 1'b1;
    wait_bit(2, 1'b1, "R8");
    check(err === 1'b1, "R8 error set on clash", err, 1);
    wr = 1'b0;
    repeat (2) @(negedge clk);
    dack = 1'b1;
    wait_bit(0, 1'b1, "R8");
    rd = 1'b0;
    wait_bit(2, 1'b0, "R8");
    dack = 1'b0;
    repeat (6) @(negedge clk);
    check(err === 1'b1, "R8 error sticky", err, 1);

    push_write("R8", "R8");
    wr = 1'b1;
    wait_bit(2, 1'b1, "R8");
    dack = 1'b1;
    wait_bit(0, 1'b1, "R8");
    wr = 1'b0;
    wait_bit(2, 1'b0, "R8");
    dack = 1'b0;
    repeat (6) @(negedge clk);
    check(err === 1'b1, "R8 error sticky after write", err, 1);
    check(exp_q.size() == 0, "R3 all expected steps seen", exp_q.size(), 0);

    // R1: reset clears the error flag
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(err === 1'b0, "R1 reset clears error", err, 0);
    check(obs === 3'b000, "R1 outputs low after reset", obs, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule